// File: doc/BRIEF.md
# Configuration-Space Base Address Register Slot

This block holds one base address register of a device's configuration header. A 64-bit memory register takes two adjacent dword slots. The register's kind (I/O, 32-bit memory, 64-bit memory or not implemented) and its requested window size are parameters. Software finds the window size with a sizing write of all ones followed by a read. It then writes the chosen base. The block keeps only the address bits that the size alignment allows. It adds the read-only type bits on every read.

The block also drives the stored base as a 64-bit value. A neighbouring address decoder uses it to claim accesses to the window. Several instances can share one configuration bus, each at its own dword offset. An instance whose offset does not match ignores the access and returns zero.

Top module: `bar_slot`

## Requirements
- R1: A requested size that is not a power of two is rounded up to the next power of two. A 6 GiB request behaves as 8 GiB, 0x3000 as 0x4000 and 20 as 32.
- R2: A legal write stores the data ANDed with the complement of (size − 1) and with the kind's base mask. The memory base mask clears bits [3:0] and the I/O base mask clears bits [1:0]. A sizing write of 0xFFFFFFFF therefore reads back the size mask.
- R3: An I/O register reads bit 0 as 1 and bit 1 as 0.
- R4: A 32-bit memory register reads bits [3:0] as 0000.
- R5: A 64-bit memory register reads bits [3:0] of its low slot as 1100: 64-bit type in bits [2:1], prefetchable in bit 3. The next dword slot holds address bits [63:32].
- R6: A write to the upper slot stores the data ANDed with bits [63:32] of the size mask.
- R7: A write is ignored unless it is a 4-byte access (cfg_size = 2) with cfg_addr[1:0] = 0. Size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved.
- R8: A slot of kind "not implemented" reads as zero, ignores writes and drives a zero base.
- R9: A read of the slot's dword gives rd_data one cycle after cfg_rd, together with rd_valid. The byte offset and size of the read do not matter. A read of any other dword returns zero. A read in the same cycle as a write returns the value from before the write.
- R10: After reset the stored base is zero. dec_base shows the new stored base from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | CFG_AW | Byte offset in configuration space |
| cfg_size | input | 2 | Access size code (0:1, 1:2, 2:4 bytes) |
| cfg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after cfg_rd |
| rd_data | output | 32 | Composed register value, or zero on a miss |
| dec_base | output | 64 | Current stored base for address decoding |

## Verification
A read and a write to the same dword can arrive in the same cycle. The bench asserts cfg_rd and cfg_wr together on the 32-bit memory slot with a new base. The scoreboard expects the old composed value in the returned data. A following read must return the new value, and dec_base must already show it. Sizing writes to the low and high halves of the 64-bit pair also test the cross-slot masking.

// File: rtl/bar_slot_pkg.sv
package bar_slot_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_IO    = 2'd1,
    KIND_MEM32 = 2'd2,
    KIND_MEM64 = 2'd3
  } bar_kind_e;

  // log2 of the smallest power of two not below req
  function automatic int size_log2(input logic [63:0] req);
    int lg;
    lg = 0;
    for (int i = 0; i < 64; i++) begin
      if ((64'd1 << i) < req) lg = i + 1;
    end
    return lg;
  endfunction

  function automatic logic [63:0] size_mask(input int lg);
    logic [63:0] span;
    span = (lg >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lg) - 64'd1);
    return ~span;
  endfunction

  function automatic logic [31:0] kind_field_mask(input bar_kind_e k);
    case (k)
      KIND_IO:    return 32'hFFFF_FFFC;
      KIND_MEM32: return 32'hFFFF_FFF0;
      KIND_MEM64: return 32'hFFFF_FFF0;
      default:    return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] kind_type_bits(input bar_kind_e k);
    case (k)
      KIND_IO:    return 32'h0000_0001;
      KIND_MEM64: return 32'h0000_000C;
      default:    return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/bar_cfg_decode.sv
module bar_cfg_decode #(
  parameter int                CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] SLOT_OFS = 8'h10,
  parameter bit                HAS_HI   = 1'b1
) (
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              rd_lo,
  output logic              rd_hi
);
  localparam int              IW     = CFG_AW - 2;
  localparam logic [IW-1:0]   LO_IDX = SLOT_OFS[CFG_AW-1:2];
  localparam logic [IW-1:0]   HI_IDX = LO_IDX + {{(IW-1){1'b0}}, 1'b1};
  localparam logic [1:0]      SZ_DWORD = 2'd2;

  logic [IW-1:0] idx;
  logic          dword_ok;
  logic          hit_lo;
  logic          hit_hi;

  always_comb begin
    idx      = cfg_addr[CFG_AW-1:2];
    dword_ok = (cfg_size == SZ_DWORD) && (cfg_addr[1:0] == 2'b00);
    hit_lo   = (idx == LO_IDX);
    hit_hi   = HAS_HI && (idx == HI_IDX);
    wr_lo    = cfg_wr && dword_ok && hit_lo;
    wr_hi    = cfg_wr && dword_ok && hit_hi;
    rd_lo    = cfg_rd && hit_lo;
    rd_hi    = cfg_rd && hit_hi;
  end

endmodule

// File: rtl/bar_base_reg.sv
module bar_base_reg #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= q_nxt;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)) else $error("base changed without write"); // R7

endmodule

// File: rtl/bar_read_port.sv
module bar_read_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_rd,
  input  logic        rd_lo,
  input  logic        rd_hi,
  input  logic [31:0] lo_view,
  input  logic [31:0] hi_view,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  logic [31:0] data_nxt;

  always_comb begin
    if (rd_lo)      data_nxt = lo_view;
    else if (rd_hi) data_nxt = hi_view;
    else            data_nxt = 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cfg_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= 32'h0;
    end else if (cfg_rd) begin
      rd_data <= data_nxt;
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> rd_valid) else $error("read not answered"); // R9

endmodule

// File: rtl/bar_slot.sv
module bar_slot
  import bar_slot_pkg::*;
#(
  parameter bar_kind_e         KIND     = KIND_MEM64,
  parameter logic [63:0]       REQ_SIZE = 64'h1_8000_0000,
  parameter int                CFG_AW   = 8,
  parameter logic [CFG_AW-1:0] SLOT_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  input  logic [31:0]       cfg_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [63:0]       dec_base
);
  localparam int          SZ_LG     = size_log2(REQ_SIZE);
  localparam logic [63:0] FULL_MASK = size_mask(SZ_LG);
  localparam bit          HAS_HI    = (KIND == KIND_MEM64);
  localparam logic [31:0] LO_KEEP   = FULL_MASK[31:0] & kind_field_mask(KIND);
  localparam logic [31:0] HI_KEEP   = HAS_HI ? FULL_MASK[63:32] : 32'h0;
  localparam logic [31:0] TYPE_BITS = kind_type_bits(KIND);

  logic        wr_lo, wr_hi, rd_lo, rd_hi;
  logic [31:0] lo_q, hi_q;
  logic [31:0] lo_view, hi_view;

  bar_cfg_decode #(
    .CFG_AW   (CFG_AW),
    .SLOT_OFS (SLOT_OFS),
    .HAS_HI   (HAS_HI)
  ) u_decode (
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .cfg_size (cfg_size),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi)
  );

  generate
    if (KIND != KIND_NONE) begin : g_lo
      bar_base_reg #(.W(32), .KEEP(LO_KEEP)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_lo),
        .wdata (cfg_wdata),
        .q     (lo_q)
      );
    end else begin : g_no_lo
      assign lo_q = 32'h0;
    end

    if (HAS_HI) begin : g_hi
      bar_base_reg #(.W(32), .KEEP(HI_KEEP)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_hi),
        .wdata (cfg_wdata),
        .q     (hi_q)
      );
    end else begin : g_no_hi
      assign hi_q = 32'h0;
    end
  endgenerate

  always_comb begin
    lo_view  = lo_q | TYPE_BITS;
    hi_view  = hi_q;
    dec_base = {hi_q, lo_q};
  end

  bar_read_port u_rdport (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_rd   (cfg_rd),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .lo_view  (lo_view),
    .hi_view  (hi_view),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_base & ~FULL_MASK) == 64'h0) else $error("base not size aligned"); // R2

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_size != 2'd2 || cfg_addr[1:0] != 2'b00)) |=> $stable(dec_base))
    else $error("illegal write altered base"); // R7

  AST_TYPE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_lo) |-> (rd_data[3:0] == TYPE_BITS[3:0]))
    else $error("type bits wrong on read"); // R3

  AST_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == KIND_NONE) |-> (dec_base == 64'h0 && rd_data == 32'h0))
    else $error("unimplemented slot not silent"); // R8

endmodule

// File: tb/bar_slot_tb.sv
module bar_slot_tb;
  import bar_slot_pkg::*;

  logic        clk, rst_n;
  logic        cfg_wr, cfg_rd;
  logic [7:0]  cfg_addr;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata;
  logic        v_m64, v_io, v_m32, v_none;
  logic [31:0] d_m64, d_io, d_m32, d_none;
  logic [63:0] b_m64, b_io, b_m32, b_none;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  bar_slot #(.KIND(KIND_MEM64), .REQ_SIZE(64'h1_8000_0000), .SLOT_OFS(8'h10)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .rd_valid(v_m64), .rd_data(d_m64),
    .dec_base(b_m64));
  bar_slot #(.KIND(KIND_IO), .REQ_SIZE(64'd20), .SLOT_OFS(8'h18)) u_dut_io (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .rd_valid(v_io), .rd_data(d_io),
    .dec_base(b_io));
  bar_slot #(.KIND(KIND_MEM32), .REQ_SIZE(64'h3000), .SLOT_OFS(8'h1C)) u_dut_m32 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .rd_valid(v_m32), .rd_data(d_m32),
    .dec_base(b_m32));
  bar_slot #(.KIND(KIND_NONE), .REQ_SIZE(64'h1000), .SLOT_OFS(8'h20)) u_dut_none (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .rd_valid(v_none), .rd_data(d_none),
    .dec_base(b_none));

  // bench model of the stored bases
  logic [31:0] m64_lo, m64_hi, io_lo, m32_lo;

  typedef struct {
    logic [31:0] v[4];
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t expect_rd(input logic [7:0] a, input string tag);
    exp_t e;
    e.v[0] = (a[7:2] == 6'h04) ? (m64_lo | 32'hC) : (a[7:2] == 6'h05) ? m64_hi : 32'h0;
    e.v[1] = (a[7:2] == 6'h06) ? (io_lo | 32'h1) : 32'h0;
    e.v[2] = (a[7:2] == 6'h07) ? m32_lo : 32'h0;
    e.v[3] = 32'h0;
    e.tag  = tag;
    return e;
  endfunction

  // one bus cycle; read expectation taken before the write lands (R9)
  task automatic access(input bit wr, input bit rd, input logic [7:0] a,
                        input logic [1:0] sz, input logic [31:0] d, input string tag);
    @(negedge clk);
    cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_size = sz; cfg_wdata = d;
    if (rd) sb.push_back(expect_rd(a, tag));
    if (wr && sz == 2'd2 && a[1:0] == 2'b00) begin
      case (a[7:2])
        6'h04: m64_lo = d & 32'h0000_0000;
        6'h05: m64_hi = d & 32'hFFFF_FFFE;
        6'h06: io_lo  = d & 32'hFFFF_FFE0;
        6'h07: m32_lo = d & 32'hFFFF_C000;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
  endtask

  task automatic check_bases(input string tag);
    check({tag, " m64 base"},  b_m64,  {m64_hi, m64_lo});
    check({tag, " io base"},   b_io,   {32'h0, io_lo});
    check({tag, " m32 base"},  b_m32,  {32'h0, m32_lo});
    check({tag, " none base"}, b_none, 64'h0);
  endtask

  // monitor: pops scoreboard items as read data appears
  always @(negedge clk) begin
    if (rst_n && v_m64) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected rd_valid, actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " m64 rd"},  {32'h0, d_m64},  {32'h0, e.v[0]});
        check({e.tag, " io rd"},   {32'h0, d_io},   {32'h0, e.v[1]});
        check({e.tag, " m32 rd"},  {32'h0, d_m32},  {32'h0, e.v[2]});
        check({e.tag, " none rd"}, {32'h0, d_none}, {32'h0, e.v[3]});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_size = 0; cfg_wdata = 0;
    m64_lo = 0; m64_hi = 0; io_lo = 0; m32_lo = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset state
    check_bases("R10 reset");
    access(0, 1, 8'h10, 2'd2, 0, "R5 reset low type");
    access(0, 1, 8'h14, 2'd2, 0, "R5 reset high");
    access(0, 1, 8'h18, 2'd2, 0, "R3 reset io type");
    access(0, 1, 8'h1C, 2'd2, 0, "R4 reset m32 type");
    access(0, 1, 8'h20, 2'd2, 0, "R8 reset none");

    // sizing writes
    access(1, 0, 8'h10, 2'd2, 32'hFFFF_FFFF, "");
    access(1, 0, 8'h14, 2'd2, 32'hFFFF_FFFF, "");
    access(1, 0, 8'h18, 2'd2, 32'hFFFF_FFFF, "");
    access(1, 0, 8'h1C, 2'd2, 32'hFFFF_FFFF, "");
    access(1, 0, 8'h20, 2'd2, 32'hFFFF_FFFF, "");
    access(0, 1, 8'h10, 2'd2, 0, "R1 R5 size low");
    access(0, 1, 8'h14, 2'd2, 0, "R6 size high");
    access(0, 1, 8'h18, 2'd2, 0, "R1 R2 R3 io size");
    access(0, 1, 8'h1C, 2'd2, 0, "R1 R2 R4 m32 size");
    access(0, 1, 8'h20, 2'd2, 0, "R8 none size");
    check_bases("R2 after sizing");

    // real bases
    access(1, 0, 8'h18, 2'd2, 32'h0000_2345, "");
    access(1, 0, 8'h1C, 2'd2, 32'h8000_5678, "");
    access(1, 0, 8'h14, 2'd2, 32'h0000_0005, "");
    check_bases("R10 R6 bases");
    access(0, 1, 8'h1A, 2'd1, 0, "R9 R3 io subdword read");

    // illegal writes
    access(1, 0, 8'h1C, 2'd0, 32'h0, "");
    access(1, 0, 8'h1E, 2'd2, 32'h0, "");
    access(1, 0, 8'h1C, 2'd3, 32'h0, "");
    access(1, 0, 8'h14, 2'd1, 32'h0, "");
    check_bases("R7 illegal writes");
    access(0, 1, 8'h1C, 2'd2, 0, "R7 m32 after illegal");

    // read and write in the same cycle
    access(1, 1, 8'h1C, 2'd2, 32'h4000_0000, "R9 same-cycle old value");
    check_bases("R10 same-cycle write");
    access(0, 1, 8'h1C, 2'd2, 0, "R9 after same-cycle");

    // other dword
    access(1, 0, 8'h24, 2'd2, 32'hFFFF_FFFF, "");
    check_bases("R8 foreign dword");
    access(0, 1, 8'h24, 2'd2, 0, "R9 foreign read");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9: actual %0d reads pending expected 0", sb.size());
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule